// File: doc/BRIEF.md
# DDR Power-Up Initialization Sequencer

This block walks a DDR memory device from reset to the point where ordinary accesses may start. After reset it waits for a stabilization flag that another block supplies once the supply and clock have settled. It then issues a fixed chain of commands: a precharge of every bank, two auto-refreshes, a load of the extended mode register and a load of the mode register. Between commands it holds the bus at NOP for a programmable number of cycles. When the last wait ends it enters a ready state, raises a done flag, and stays there.

The outputs are the current step, a four-bit command code and the bank and row-address values for that command. A separate pin driver turns these into device signals. The minimum precharge, refresh and mode-load gaps are given as parameters in clock cycles. The values loaded into both mode registers are also parameters.

Top module: `dram_init_seq`

## Requirements
- R1: While rst_ni is low, with no clock edge needed, state_o is 0, cmd_o is NOP (4'b0111), ba_o and addr_o are zero and init_done_o is low.
- R2: After reset the sequencer stays in IDLE (state 0) with NOP on the bus for as long as stab_done_i is sampled low.
- R3: The first rising edge that samples stab_done_i high moves to the NOP step (state 1). The next edge moves to the precharge step (state 2), which drives cmd_o = 4'b0010 with addr_o bit 10 high, every other address bit low and ba_o = 0.
- R4: The first auto-refresh (state 3, cmd_o = 4'b0001) comes T_RP cycles after the precharge. The second (state 4, same code) comes T_RFC cycles after the first.
- R5: The extended mode load (state 5, cmd_o = 4'b0000, ba_o = 2'b01, addr_o = EMR_VAL) comes T_RFC cycles after the second refresh.
- R6: The mode load (state 6, cmd_o = 4'b0000, ba_o = 2'b00, addr_o = MR_VAL) comes T_MRD cycles after the extended mode load.
- R7: T_MRD cycles after the mode load the sequencer enters READY (state 7) and raises init_done_o. It stays there, with stab_done_i having no effect, until the next reset.
- R8: In every cycle that does not issue a command (wait cycles, IDLE, NOP step, READY), cmd_o is NOP and ba_o and addr_o are zero.
- R9: A command is driven for exactly one cycle, the first cycle of its step. state_o reports that step.
- R10: A reset in the middle of the sequence returns to IDLE at once. After release the whole chain restarts from the precharge and again waits for stab_done_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stab_done_i | input | 1 | Stabilization interval has elapsed |
| state_o | output | 3 | Current step, 0 (IDLE) to 7 (READY) |
| cmd_o | output | 4 | Command code {cs_n, ras_n, cas_n, we_n} |
| ba_o | output | 2 | Bank address for the command |
| addr_o | output | ADDR_W | Row-address value for the command |
| init_done_o | output | 1 | High while in READY |

## Verification
All outputs are decoded from registered state with no further register, so each one is valid in the cycle after the edge that changes the step. With the edge that samples stab_done_i high counted as cycle 0, the precharge appears in cycle 1. The refreshes follow at 1+T_RP and 1+T_RP+T_RFC, the extended mode load at 1+T_RP+2*T_RFC, the mode load T_MRD after that, and READY T_MRD later again. The bench keeps a table of these cycle numbers and compares every cycle at the falling edge. In each cycle it expects the most recent step, with the command present only in that step's own listed cycle. Resets are applied and checked between edges, because the reset acts without the clock.

// File: rtl/dram_init_pkg.sv
package dram_init_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_NOP   = 3'd1,
    ST_PRE   = 3'd2,
    ST_AR1   = 3'd3,
    ST_AR2   = 3'd4,
    ST_EMRS  = 3'd5,
    ST_MRS   = 3'd6,
    ST_READY = 3'd7
  } init_state_e;

  typedef logic [3:0] dram_cmd_t;  // {cs_n, ras_n, cas_n, we_n}
  localparam dram_cmd_t CMD_NOP = 4'b0111;
  localparam dram_cmd_t CMD_PRE = 4'b0010;
  localparam dram_cmd_t CMD_REF = 4'b0001;
  localparam dram_cmd_t CMD_LMR = 4'b0000;
endpackage

// File: rtl/init_wait_ctr.sv
module init_wait_ctr #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/init_step_fsm.sv
module init_step_fsm
  import dram_init_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int T_RP  = 3,
  parameter int T_RFC = 8,
  parameter int T_MRD = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stab_i,
  input  logic             wait_done_i,
  output init_state_e      state_o,
  output logic             issue_o,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o
);
  // counter holds remaining extra cycles of a step: wait W -> load W-1
  localparam logic [CNT_W-1:0] LD_RP  = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0] LD_RFC = CNT_W'(T_RFC - 1);
  localparam logic [CNT_W-1:0] LD_MRD = CNT_W'(T_MRD - 1);

  init_state_e state_q, state_d;
  logic        issue_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (stab_i)      state_d = ST_NOP;
      ST_NOP:                    state_d = ST_PRE;
      ST_PRE:   if (wait_done_i) state_d = ST_AR1;
      ST_AR1:   if (wait_done_i) state_d = ST_AR2;
      ST_AR2:   if (wait_done_i) state_d = ST_EMRS;
      ST_EMRS:  if (wait_done_i) state_d = ST_MRS;
      ST_MRS:   if (wait_done_i) state_d = ST_READY;
      ST_READY:                  state_d = ST_READY;
      default:                   state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (state_d)
      ST_PRE:          load_val_o = LD_RP;
      ST_AR1, ST_AR2:  load_val_o = LD_RFC;
      ST_EMRS, ST_MRS: load_val_o = LD_MRD;
      default:         load_val_o = '0;
    endcase
  end

  assign load_o = (state_d != state_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      issue_q <= 1'b0;
    end else begin
      state_q <= state_d;
      issue_q <= load_o;
    end
  end

  assign state_o = state_q;
  assign issue_o = issue_q;
endmodule

// File: rtl/init_cmd_enc.sv
module init_cmd_enc
  import dram_init_pkg::*;
#(
  parameter int                ADDR_W  = 13,
  parameter logic [ADDR_W-1:0] MR_VAL  = '0,
  parameter logic [ADDR_W-1:0] EMR_VAL = '0
) (
  input  init_state_e        state_i,
  input  logic               issue_i,
  output logic [3:0]         cmd_o,
  output logic [1:0]         ba_o,
  output logic [ADDR_W-1:0]  addr_o
);
  localparam int AP_BIT = 10;  // all-bank select on precharge

  always_comb begin
    cmd_o  = CMD_NOP;
    ba_o   = 2'b00;
    addr_o = '0;
    if (issue_i) begin
      unique case (state_i)
        ST_PRE: begin
          cmd_o          = CMD_PRE;
          addr_o[AP_BIT] = 1'b1;
        end
        ST_AR1, ST_AR2: cmd_o = CMD_REF;
        ST_EMRS: begin
          cmd_o  = CMD_LMR;
          ba_o   = 2'b01;
          addr_o = EMR_VAL;
        end
        ST_MRS: begin
          cmd_o  = CMD_LMR;
          addr_o = MR_VAL;
        end
        default: cmd_o = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/dram_init_seq.sv
module dram_init_seq
  import dram_init_pkg::*;
#(
  parameter int                ADDR_W  = 13,
  parameter int                T_RP    = 3,
  parameter int                T_RFC   = 8,
  parameter int                T_MRD   = 2,
  parameter logic [ADDR_W-1:0] MR_VAL  = 13'h0032,
  parameter logic [ADDR_W-1:0] EMR_VAL = 13'h0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stab_done_i,
  output logic [2:0]        state_o,
  output logic [3:0]        cmd_o,
  output logic [1:0]        ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              init_done_o
);
  localparam int T_MAX = (T_RP > T_RFC) ? ((T_RP > T_MRD) ? T_RP : T_MRD)
                                        : ((T_RFC > T_MRD) ? T_RFC : T_MRD);
  localparam int CNT_W = (T_MAX < 2) ? 1 : $clog2(T_MAX);

  init_state_e      state;
  logic             issue, load, wait_done;
  logic [CNT_W-1:0] load_val;

  init_step_fsm #(
    .CNT_W(CNT_W), .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stab_i     (stab_done_i),
    .wait_done_i(wait_done),
    .state_o    (state),
    .issue_o    (issue),
    .load_o     (load),
    .load_val_o (load_val)
  );

  init_wait_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .load_val_i(load_val),
    .zero_o    (wait_done)
  );

  init_cmd_enc #(
    .ADDR_W(ADDR_W), .MR_VAL(MR_VAL), .EMR_VAL(EMR_VAL)
  ) u_enc (
    .state_i(state),
    .issue_i(issue),
    .cmd_o  (cmd_o),
    .ba_o   (ba_o),
    .addr_o (addr_o)
  );

  assign state_o     = state;
  assign init_done_o = (state == ST_READY);
endmodule

// File: rtl/dram_init_seq_chk.sv
module dram_init_seq_chk #(
  parameter int ADDR_W = 13,
  parameter int T_RP   = 3,
  parameter int T_MRD  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              stab_done_i,
  input logic [2:0]        state_o,
  input logic [3:0]        cmd_o,
  input logic [1:0]        ba_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              init_done_o
);
  logic [7:0] gap_q;
  logic [3:0] prev_cmd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q      <= 8'd0;
      prev_cmd_q <= 4'b0111;
    end else if (cmd_o != 4'b0111) begin
      gap_q      <= 8'd1;
      prev_cmd_q <= cmd_o;
    end else if (gap_q != 8'hff) begin
      gap_q <= gap_q + 8'd1;
    end
  end

  assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd0 && !stab_done_i) |=> (state_o == 3'd0));

  assert_nop_to_pre_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd1) |=> (state_o == 3'd2 && cmd_o == 4'b0010));

  assert_pre_allbank_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == 4'b0010) |-> (addr_o[10] && ba_o == 2'b00));

  assert_pre_spacing_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == 4'b0001 && prev_cmd_q == 4'b0010) |-> (gap_q == 8'(T_RP)));

  assert_mrs_spacing_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd6 && cmd_o == 4'b0000) |-> (gap_q == 8'(T_MRD)));

  assert_ready_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> (init_done_o && state_o == 3'd7));

  assert_ready_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |-> (cmd_o == 4'b0111 && ba_o == 2'b00 && addr_o == '0));

  assert_single_issue_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o != 4'b0111) |=> (cmd_o == 4'b0111 || state_o != $past(state_o)));
endmodule

bind dram_init_seq dram_init_seq_chk #(
  .ADDR_W(ADDR_W), .T_RP(T_RP), .T_MRD(T_MRD)
) u_chk (.*);

// File: tb/dram_init_seq_bench.sv
module dram_init_seq_bench;
  localparam int ADDR_W = 13;
  localparam int T_RP = 3, T_RFC = 8, T_MRD = 2;
  localparam logic [ADDR_W-1:0] MR_V  = 13'h0032;
  localparam logic [ADDR_W-1:0] EMR_V = 13'h0004;
  localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010, REF = 4'b0001, LMR = 4'b0000;

  typedef struct packed {
    logic [7:0]        k;
    logic [2:0]        st;
    logic [3:0]        cmd;
    logic [1:0]        ba;
    logic [ADDR_W-1:0] addr;
  } ev_t;

  localparam int K_PRE  = 1;
  localparam int K_AR1  = K_PRE + T_RP;
  localparam int K_AR2  = K_AR1 + T_RFC;
  localparam int K_EMRS = K_AR2 + T_RFC;
  localparam int K_MRS  = K_EMRS + T_MRD;
  localparam int K_RDY  = K_MRS + T_MRD;
  localparam int N_EV   = 7;
  localparam ev_t EV [N_EV] = '{
    '{8'(0),      3'd1, NOP, 2'b00, 13'h0000},
    '{8'(K_PRE),  3'd2, PRE, 2'b00, 13'h0400},
    '{8'(K_AR1),  3'd3, REF, 2'b00, 13'h0000},
    '{8'(K_AR2),  3'd4, REF, 2'b00, 13'h0000},
    '{8'(K_EMRS), 3'd5, LMR, 2'b01, EMR_V},
    '{8'(K_MRS),  3'd6, LMR, 2'b00, MR_V},
    '{8'(K_RDY),  3'd7, NOP, 2'b00, 13'h0000}
  };
  localparam string EV_REQ [N_EV] = '{"R3", "R3", "R4", "R4", "R5", "R6", "R7"};

  logic clk = 1'b0, rst_n = 1'b0, stab = 1'b0;
  logic [2:0] state; logic [3:0] cmd; logic [1:0] ba;
  logic [ADDR_W-1:0] addr; logic done;
  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dram_init_seq #(
    .ADDR_W(ADDR_W), .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD),
    .MR_VAL(MR_V), .EMR_VAL(EMR_V)
  ) u_dram_init_seq (
    .clk_i(clk), .rst_ni(rst_n), .stab_done_i(stab), .state_o(state),
    .cmd_o(cmd), .ba_o(ba), .addr_o(addr), .init_done_o(done)
  );

  task automatic check(string req, logic [2:0] est, logic [3:0] ecmd,
                       logic [1:0] eba, logic [ADDR_W-1:0] eaddr);
    logic [22:0] act, exp;
    act = {state, cmd, ba, addr, done};
    exp = {est, ecmd, eba, eaddr, (est == 3'd7)};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0t act st=%0d cmd=%b ba=%b addr=%h done=%b exp st=%0d cmd=%b ba=%b addr=%h done=%b",
               req, $time, state, cmd, ba, addr, done, est, ecmd, eba, eaddr, est == 3'd7);
    end
  endtask

  // Walk cycles 0..last after the edge that samples stab high.
  task automatic walk(int last, int drop_stab_at);
    for (int k = 0; k <= last; k++) begin
      int idx;
      @(posedge clk); @(negedge clk);
      idx = 0;
      for (int e = 0; e < N_EV; e++) if (int'(EV[e].k) <= k) idx = e;
      if (int'(EV[idx].k) == k)
        check(EV_REQ[idx], EV[idx].st, EV[idx].cmd, EV[idx].ba, EV[idx].addr);
      else
        check("R8", EV[idx].st, NOP, 2'b00, '0);
      if (k == drop_stab_at) stab = 1'b0;
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #1;
    check("R1", 3'd0, NOP, 2'b00, '0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(posedge clk); @(negedge clk);
      check("R2", 3'd0, NOP, 2'b00, '0);
    end
    // full sequence; stab dropped inside READY must be ignored (R7)
    stab = 1'b1;
    walk(K_RDY + 8, K_RDY + 2);
    // async reset from READY
    #1 rst_n = 1'b0; #0.5;
    check("R1", 3'd0, NOP, 2'b00, '0);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); @(negedge clk);
      check("R10", 3'd0, NOP, 2'b00, '0);
    end
    // start, then reset in the middle of the refresh wait
    stab = 1'b1;
    walk(K_AR1 + 2, -1);
    #1 rst_n = 1'b0; #0.5;
    check("R10", 3'd0, NOP, 2'b00, '0);
    @(negedge clk); rst_n = 1'b1;
    // stab still high: chain restarts from the top
    walk(K_AR1, -1);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule